// File: doc/BRIEF.md
# Bus Cycle Trace Line Formatter

This block turns one snapshot of a processor bus per clock step into one line of printable ASCII text. It reads the snapshot on a valid/ready pair. The snapshot holds the number of steps still to run, the address, the transfer direction, the data value and the levels of the three active-low control lines (reset, NMI, IRQ). The block sends the line out one byte at a time on a second valid/ready pair, so it can feed a serial transmitter directly.

The controller that steps the processor may run ahead of the slow character stream. A small record queue sits between the capture side and the text side to absorb this. When the queue is full, the block lowers its capture-ready output and the stepping controller waits. Records are never dropped.

Each line is 20 bytes long: a three-column decimal step count, a colon, four hex address digits, a space, `r` or `w`, a space, two hex data digits, a space, three flag columns, the prompt `>`, then CR and LF.

Top module: `trace_line_fmt`

## Requirements
- R1: A step count above 999 is printed as `999`; any count from 0 to 999 is printed as its exact decimal value.
- R2: The step count fills byte columns 0 to 2, right-aligned, with leading zeros shown as spaces. A count of zero prints as `  0`. Column 3 is `:`.
- R3: Columns 4 to 7 are the 16-bit address as lowercase hex, most significant nibble first. Column 8 is a space.
- R4: Column 9 is `r` when `bus_is_read` is 1 and `w` when it is 0. Column 10 is a space.
- R5: Columns 11 and 12 are the data byte as lowercase hex, high nibble first. Column 13 is a space.
- R6: Columns 14, 15 and 16 show `R`, `N` and `I` when `rst_line_n`, `nmi_line_n` and `irq_line_n` respectively are 0, and a space when the line is 1.
- R7: Column 17 is `>`, column 18 is CR (0x0D) and column 19 is LF (0x0A). Each line is exactly 20 bytes.
- R8: Lines come out in the order their records were accepted, with none lost or repeated. The queue holds DEPTH records (default 4).
- R9: `cyc_ready` is low exactly when DEPTH records are held. A `cyc_valid` that is presented while `cyc_ready` is low is ignored and produces no line.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_byte` holds its value.
- R11: After a synchronous reset, `out_valid` is 0 and `cyc_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_valid | input | 1 | A bus-step record is presented |
| cyc_ready | output | 1 | The block can accept a record |
| cyc_left | input | CNT_W | Steps still to run |
| bus_addr | input | 16 | Address bus |
| bus_is_read | input | 1 | 1 = read, 0 = write |
| bus_data | input | 8 | Data bus |
| rst_line_n | input | 1 | Reset line level, active low |
| nmi_line_n | input | 1 | NMI line level, active low |
| irq_line_n | input | 1 | IRQ line level, active low |
| out_valid | output | 1 | `out_byte` holds a character |
| out_ready | input | 1 | The sink takes the character |
| out_byte | output | 8 | ASCII character |

## Verification
The bench targets these step counts: 0, 9, 10, 99, 100, 999, 1000 and the maximum value. A mistake in blanking or saturation would show up as a stray `0`, a missing digit or a wrapped value such as `536`. The bench fills the queue while the sink is stalled. A design that dropped or overwrote a record would then produce a missing line or a repeated line. A design that let a capture through while full would produce an extra line. The bench holds `out_ready` low for several cycles. A design that advanced the column during the stall would skip or change characters. The bench also drives random address, data and line patterns, which exposes uppercase hex, swapped nibbles and flag columns in the wrong position.

// File: rtl/trace_fmt_pkg.sv
package trace_fmt_pkg;

    localparam int LINE_LEN = 20;
    localparam int IDX_W    = $clog2(LINE_LEN);
    localparam int SAT_MAX  = 999;

    localparam logic [7:0] CH_SP    = 8'h20;
    localparam logic [7:0] CH_COLON = 8'h3A;
    localparam logic [7:0] CH_PROMPT= 8'h3E;
    localparam logic [7:0] CH_CR    = 8'h0D;
    localparam logic [7:0] CH_LF    = 8'h0A;

    typedef struct packed {
        logic [3:0]  hund;
        logic [3:0]  tens;
        logic [3:0]  ones;
        logic [15:0] addr;
        logic        is_read;
        logic [7:0]  data;
        logic        rst_low;
        logic        nmi_low;
        logic        irq_low;
    } trace_rec_t;

    typedef enum logic [2:0] {
        FLD_COUNT,
        FLD_ADDR,
        FLD_DIR,
        FLD_DATA,
        FLD_FLAGS,
        FLD_TAIL
    } field_e;

    function automatic logic [7:0] hex_ascii(input logic [3:0] n);
        if (n < 4'd10) return 8'h30 + {4'h0, n};
        return 8'h61 + {4'h0, n} - 8'd10;
    endfunction

    function automatic logic [7:0] dec_ascii(input logic [3:0] n);
        return 8'h30 + {4'h0, n};
    endfunction

    function automatic logic [7:0] flag_ascii(input logic active, input logic [7:0] letter);
        return active ? letter : CH_SP;
    endfunction

    function automatic field_e field_of(input logic [IDX_W-1:0] idx);
        if (idx < 5'd4)  return FLD_COUNT;
        if (idx < 5'd9)  return FLD_ADDR;
        if (idx < 5'd11) return FLD_DIR;
        if (idx < 5'd14) return FLD_DATA;
        if (idx < 5'd17) return FLD_FLAGS;
        return FLD_TAIL;
    endfunction

endpackage

// File: rtl/trace_cycle_encode.sv
module trace_cycle_encode
    import trace_fmt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] cyc_left,
    input  logic [15:0]      bus_addr,
    input  logic             bus_is_read,
    input  logic [7:0]       bus_data,
    input  logic             rst_line_n,
    input  logic             nmi_line_n,
    input  logic             irq_line_n,
    output trace_rec_t       rec
);
    localparam int SAT_W = 10;

    logic [SAT_W-1:0] sat;
    logic [SAT_W-1:0] rem_h;
    logic [SAT_W-1:0] q_h;
    logic [SAT_W-1:0] q_t;
    logic [SAT_W-1:0] q_o;

    generate
        if (CNT_W > SAT_W) begin : g_wide
            always_comb begin
                if (cyc_left > CNT_W'(SAT_MAX)) sat = SAT_W'(SAT_MAX);
                else                            sat = cyc_left[SAT_W-1:0];
            end
        end else begin : g_narrow
            logic [SAT_W-1:0] ext;
            assign ext = SAT_W'(cyc_left);
            always_comb begin
                if (ext > SAT_W'(SAT_MAX)) sat = SAT_W'(SAT_MAX);
                else                       sat = ext;
            end
        end
    endgenerate

    always_comb begin
        q_h   = sat / SAT_W'(100);
        rem_h = sat - q_h * SAT_W'(100);
        q_t   = rem_h / SAT_W'(10);
        q_o   = rem_h - q_t * SAT_W'(10);
    end

    always_comb begin
        rec.hund    = q_h[3:0];
        rec.tens    = q_t[3:0];
        rec.ones    = q_o[3:0];
        rec.addr    = bus_addr;
        rec.is_read = bus_is_read;
        rec.data    = bus_data;
        rec.rst_low = ~rst_line_n;
        rec.nmi_low = ~nmi_line_n;
        rec.irq_low = ~irq_line_n;
    end

endmodule

// File: rtl/trace_rec_fifo.sv
module trace_rec_fifo
    import trace_fmt_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       push,
    input  trace_rec_t push_rec,
    input  logic       pop,
    output trace_rec_t head_rec,
    output logic       full,
    output logic       empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int PW = AW + 1;

    trace_rec_t    mem [DEPTH];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;

    assign empty    = (wr_ptr == rd_ptr);
    assign full     = (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]) && (wr_ptr[AW] != rd_ptr[AW]);
    assign head_rec = mem[rd_ptr[AW-1:0]];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push && !full) begin
                mem[wr_ptr[AW-1:0]] <= push_rec;
                wr_ptr <= wr_ptr + PW'(1);
            end
            if (pop && !empty) begin
                rd_ptr <= rd_ptr + PW'(1);
            end
        end
    end

endmodule

// File: rtl/trace_line_render.sv
module trace_line_render
    import trace_fmt_pkg::*;
(
    input  trace_rec_t       rec,
    input  logic [IDX_W-1:0] idx,
    output logic [7:0]       ch
);
    field_e fld;
    logic   hund_blank;
    logic   tens_blank;

    assign fld        = field_of(idx);
    assign hund_blank = (rec.hund == 4'd0);
    assign tens_blank = hund_blank && (rec.tens == 4'd0);

    always_comb begin
        ch = CH_SP;
        unique case (fld)
            FLD_COUNT: begin
                case (idx)
                    5'd0:    ch = hund_blank ? CH_SP : dec_ascii(rec.hund);
                    5'd1:    ch = tens_blank ? CH_SP : dec_ascii(rec.tens);
                    5'd2:    ch = dec_ascii(rec.ones);
                    default: ch = CH_COLON;
                endcase
            end
            FLD_ADDR: begin
                case (idx)
                    5'd4:    ch = hex_ascii(rec.addr[15:12]);
                    5'd5:    ch = hex_ascii(rec.addr[11:8]);
                    5'd6:    ch = hex_ascii(rec.addr[7:4]);
                    5'd7:    ch = hex_ascii(rec.addr[3:0]);
                    default: ch = CH_SP;
                endcase
            end
            FLD_DIR: begin
                if (idx == 5'd9) ch = rec.is_read ? 8'h72 : 8'h77;
                else             ch = CH_SP;
            end
            FLD_DATA: begin
                case (idx)
                    5'd11:   ch = hex_ascii(rec.data[7:4]);
                    5'd12:   ch = hex_ascii(rec.data[3:0]);
                    default: ch = CH_SP;
                endcase
            end
            FLD_FLAGS: begin
                case (idx)
                    5'd14:   ch = flag_ascii(rec.rst_low, 8'h52);
                    5'd15:   ch = flag_ascii(rec.nmi_low, 8'h4E);
                    default: ch = flag_ascii(rec.irq_low, 8'h49);
                endcase
            end
            FLD_TAIL: begin
                case (idx)
                    5'd17:   ch = CH_PROMPT;
                    5'd18:   ch = CH_CR;
                    default: ch = CH_LF;
                endcase
            end
            default: ch = CH_SP;
        endcase
    end

endmodule

// File: rtl/trace_line_seq.sv
module trace_line_seq
    import trace_fmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             have_rec,
    input  logic             out_ready,
    output logic             out_valid,
    output logic [IDX_W-1:0] idx,
    output logic             line_done
);
    logic last_col;

    assign out_valid = have_rec;
    assign last_col  = (idx == IDX_W'(LINE_LEN - 1));
    assign line_done = out_valid && out_ready && last_col;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx <= '0;
        end else if (out_valid && out_ready) begin
            idx <= last_col ? '0 : idx + IDX_W'(1);
        end
    end

endmodule

// File: rtl/trace_line_fmt.sv
module trace_line_fmt
    import trace_fmt_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cyc_valid,
    output logic             cyc_ready,
    input  logic [CNT_W-1:0] cyc_left,
    input  logic [15:0]      bus_addr,
    input  logic             bus_is_read,
    input  logic [7:0]       bus_data,
    input  logic             rst_line_n,
    input  logic             nmi_line_n,
    input  logic             irq_line_n,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [7:0]       out_byte
);
    trace_rec_t       in_rec;
    trace_rec_t       head_rec;
    logic             q_full;
    logic             q_empty;
    logic             line_done;
    logic [IDX_W-1:0] col;

    trace_cycle_encode #(.CNT_W(CNT_W)) u_encode (
        .cyc_left    (cyc_left),
        .bus_addr    (bus_addr),
        .bus_is_read (bus_is_read),
        .bus_data    (bus_data),
        .rst_line_n  (rst_line_n),
        .nmi_line_n  (nmi_line_n),
        .irq_line_n  (irq_line_n),
        .rec         (in_rec)
    );

    trace_rec_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .push     (cyc_valid),
        .push_rec (in_rec),
        .pop      (line_done),
        .head_rec (head_rec),
        .full     (q_full),
        .empty    (q_empty)
    );

    trace_line_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .have_rec  (!q_empty),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .idx       (col),
        .line_done (line_done)
    );

    trace_line_render u_render (
        .rec (head_rec),
        .idx (col),
        .ch  (out_byte)
    );

    assign cyc_ready = !q_full;

endmodule

// File: rtl/trace_line_fmt_chk.sv
module trace_line_fmt_chk #(
    parameter int DEPTH = 4
) (
    input logic       clk,
    input logic       rst,
    input logic       cyc_valid,
    input logic       cyc_ready,
    input logic       out_valid,
    input logic       out_ready,
    input logic [7:0] out_byte
);
    localparam int OW = $clog2(DEPTH) + 2;

    logic [OW-1:0] occ;
    logic          took;
    logic          gave;

    assign took = cyc_valid && cyc_ready;
    assign gave = out_valid && out_ready && (out_byte == 8'h0A);

    always_ff @(posedge clk) begin
        if (rst) occ <= '0;
        else     occ <= occ + OW'(took) - OW'(gave);
    end

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
        occ <= OW'(DEPTH));

    assert_valid_follows_occupancy_R8: assert property (@(posedge clk) disable iff (rst)
        out_valid == (occ != '0));

    assert_ready_tracks_space_R9: assert property (@(posedge clk) disable iff (rst)
        cyc_ready == (occ < OW'(DEPTH)));

    assert_hold_under_stall_R10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_byte)));

    assert_cr_then_lf_R7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_byte == 8'h0D) |=> (out_valid && out_byte == 8'h0A));

    assert_reset_idle_R11: assert property (@(posedge clk)
        rst |=> (!out_valid && cyc_ready));

endmodule

bind trace_line_fmt trace_line_fmt_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cyc_valid (cyc_valid),
    .cyc_ready (cyc_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_byte  (out_byte)
);

// File: tb/trace_line_fmt_bench.sv
module trace_line_fmt_bench;
    localparam int CNT_W = 16;
    localparam int DEPTH = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cyc_valid = 1'b0;
    logic             cyc_ready;
    logic [CNT_W-1:0] cyc_left = '0;
    logic [15:0]      bus_addr = '0;
    logic             bus_is_read = 1'b1;
    logic [7:0]       bus_data = '0;
    logic             rst_line_n = 1'b1;
    logic             nmi_line_n = 1'b1;
    logic             irq_line_n = 1'b1;
    logic             out_valid;
    logic             out_ready = 1'b0;
    logic [7:0]       out_byte;

    int   nchk = 0;
    int   nfail = 0;
    int   rdy_mode = 0;
    bit   done = 0;
    byte  exp_q[$];
    int   col_q[$];
    logic [7:0] held;

    always #4 clk = ~clk;

    trace_line_fmt #(.CNT_W(CNT_W), .DEPTH(DEPTH)) u_trace_line_fmt (.*);

    function automatic string req_of(int col, int big);
        if (col < 4)  return (big != 0) ? "R1" : "R2";
        if (col < 9)  return "R3";
        if (col < 11) return "R4";
        if (col < 14) return "R5";
        if (col < 17) return "R6";
        return "R7";
    endfunction

    function automatic string line_text(int cnt, logic [15:0] a, logic rd, logic [7:0] d,
                                        logic rn, logic nn, logic in_n);
        int shown;
        shown = (cnt > 999) ? 999 : cnt;
        return $sformatf("%3d:%04h %s %02h %s%s%s>", shown, a, rd ? "r" : "w", d,
                         rn ? " " : "R", nn ? " " : "N", in_n ? " " : "I");
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Sink side: picks out_ready each cycle and compares every byte taken.
    always begin
        @(negedge clk);
        case (rdy_mode)
            0:       out_ready = 1'b0;
            1:       out_ready = ($urandom % 2) == 0;
            default: out_ready = 1'b1;
        endcase
        #1;
        if (!rst && out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R9", "byte with no accepted record", int'(out_byte), 0);
            end else begin
                byte e;
                int  c;
                e = exp_q.pop_front();
                c = col_q.pop_front();
                check(out_byte == e, req_of(c % 100, c / 100), $sformatf("column %0d", c % 100),
                      int'(out_byte), int'(e));
            end
        end
    end

    task automatic push(int cnt, logic [15:0] a, logic rd, logic [7:0] d,
                        logic rn, logic nn, logic in_n);
        string s;
        @(negedge clk);
        cyc_valid   = 1'b1;
        cyc_left    = CNT_W'(cnt);
        bus_addr    = a;
        bus_is_read = rd;
        bus_data    = d;
        rst_line_n  = rn;
        nmi_line_n  = nn;
        irq_line_n  = in_n;
        #1;
        while (!cyc_ready) begin
            @(negedge clk);
            #1;
        end
        s = line_text(cnt, a, rd, d, rn, nn, in_n);
        for (int i = 0; i < 18; i++) begin
            exp_q.push_back(s[i]);
            col_q.push_back(i + ((cnt > 999) ? 100 : 0));
        end
        exp_q.push_back(8'h0D); col_q.push_back(18);
        exp_q.push_back(8'h0A); col_q.push_back(19);
        @(posedge clk);
        #1;
        cyc_valid = 1'b0;
    endtask

    task automatic drain();
        rdy_mode = 2;
        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL R8 watchdog expired: actual %0d expected %0d", exp_q.size(), 0);
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        @(negedge clk);
        #1;
        // R11: idle after reset
        check(out_valid == 1'b0, "R11", "out_valid after reset", int'(out_valid), 0);
        check(cyc_ready == 1'b1, "R11", "cyc_ready after reset", int'(cyc_ready), 1);

        // R1/R2 directed counts around blanking and saturation
        rdy_mode = 2;
        push(0,     16'h0000, 1'b1, 8'h00, 1'b0, 1'b1, 1'b1);
        push(9,     16'habcd, 1'b0, 8'hef, 1'b1, 1'b0, 1'b1);
        push(10,    16'h1234, 1'b1, 8'h5a, 1'b1, 1'b1, 1'b0);
        push(99,    16'hffff, 1'b0, 8'hff, 1'b0, 1'b0, 1'b0);
        push(100,   16'h01f7, 1'b1, 8'hea, 1'b1, 1'b1, 1'b1);
        push(999,   16'hfffc, 1'b1, 8'h09, 1'b0, 1'b1, 1'b0);
        push(1000,  16'h0a0b, 1'b0, 8'hc3, 1'b1, 1'b0, 1'b0);
        push(65535, 16'h8000, 1'b1, 8'h80, 1'b0, 1'b0, 1'b1);
        drain();

        // R9/R10: fill the queue while the sink stalls
        rdy_mode = 0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < DEPTH; i++)
            push(500 + i, 16'(16'h0400 + i), 1'b1, 8'(8'h40 + i), 1'b1, 1'b1, 1'b1);
        @(negedge clk);
        #1;
        check(cyc_ready == 1'b0, "R9", "cyc_ready with full queue", int'(cyc_ready), 0);
        held = out_byte;
        // offered while full: must be ignored (no expected bytes are queued)
        cyc_valid = 1'b1;
        cyc_left  = 16'd7;
        bus_addr  = 16'hdead;
        repeat (3) @(negedge clk);
        #1;
        check(out_valid == 1'b1, "R10", "out_valid under stall", int'(out_valid), 1);
        check(out_byte == held, "R10", "out_byte under stall", int'(out_byte), int'(held));
        check(cyc_ready == 1'b0, "R9", "cyc_ready still low", int'(cyc_ready), 0);
        cyc_valid = 1'b0;
        drain();
        repeat (5) @(negedge clk);
        #1;
        check(out_valid == 1'b0, "R9", "no line from ignored record", int'(out_valid), 0);
        check(cyc_ready == 1'b1, "R8", "queue empty again", int'(cyc_ready), 1);

        // R8: random records with random backpressure
        rdy_mode = 1;
        for (int n = 0; n < 150; n++) begin
            int cnt;
            case ($urandom % 4)
                0:       cnt = $urandom % 10;
                1:       cnt = $urandom % 1000;
                2:       cnt = 995 + ($urandom % 10);
                default: cnt = $urandom % 65536;
            endcase
            push(cnt, 16'($urandom), 1'($urandom), 8'($urandom),
                 1'($urandom), 1'($urandom), 1'($urandom));
        end
        drain();
        check(exp_q.size() == 0, "R8", "all lines delivered", exp_q.size(), 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule